// File: doc/BRIEF.md
# Compute Unit Record Controller

This block is the control half of one compute unit. It owns a 64-byte data record, held as 16 words of 32 bits, and the state machine that loads the record, starts a command, waits for it to finish, reports completion and returns the unit to the free pool once the result has been acknowledged. A scheduler fills the record through a load/write port, pulses `run_i`, watches `done_o`, optionally reads words back, and raises `thanks_i` to release the unit.

Word 0 carries the task header. Its bytes, from least significant, are the frame tag, the command byte, the first argument and the second argument. The low seven bits of the command byte select the operation. A no-operation command is timed inside the block and waits for as many cycles as its first argument says. The two computing commands are handed to an external engine over a one-cycle start strobe and a busy level. Any unknown code runs as a no-operation. A run issued while the unit is free and without a fresh load repeats the command on the record as it stands. This lets a scheduler chain several commands on one data set. Holding `abort_i` forces the control state back to free within one clock and leaves the record untouched.

States: FREE (unit available), FILL (load seen, taking writes), DECODE (command byte examined, timer loaded), WAIT_NOP (counting down), KICK (engine strobe), WAIT_ENG (waiting for busy to fall), RESULT (done held). Transitions: FREE→DECODE on run, FREE→FILL on load without run, FILL→DECODE on run, DECODE→WAIT_NOP for no-operation or unknown codes, DECODE→KICK for the two computing codes, WAIT_NOP→RESULT when the timer reaches zero, KICK→WAIT_ENG always, WAIT_ENG→RESULT when busy is low, RESULT→FREE on thanks. Any state→FREE on abort or reset.

Top module: `cu_ctrl`

## Requirements
- R1: After reset `avail_o` is 1, `done_o` and `eng_start_o` are 0, and every record word reads back as 0, so `frame_id_o` and `final_o` are 0.
- R2: A word is stored only on a clock where `load_i` and `wr_i` are high, `run_i` is low and the unit is in FREE or FILL. Writes in any other state, including the busy states and RESULT, leave the record unchanged.
- R3: `avail_o` falls on the clock after the first cycle in which `load_i` or `run_i` is seen in FREE. Once RESULT is reached it stays low until `thanks_i` (or abort).
- R4: A no-operation command leaves the record unchanged. `done_o` rises exactly arg0+2 clock edges after the edge that samples `run_i`, where arg0 is word 0 bits 23:16.
- R5: The opcode is word 0 bits 14:8. The value 1 starts the engine with `eng_op_o`=1, and the value 2 starts it with `eng_op_o`=2. Every other value, whatever bit 15 holds, runs as a no-operation and gives no start strobe.
- R6: For an engine command, `eng_start_o` is high for exactly one cycle, on the clock after the run edge. `done_o` rises on the edge that first samples `eng_busy_i` low in WAIT_ENG.
- R7: `done_o` stays high until `thanks_i` is sampled. `avail_o` is 1 on the clock after that.
- R8: When `rd_i` is sampled high, `rdata_o` holds the word at `raddr_i` from the next clock on.
- R9: `frame_id_o` equals word 0 bits 7:0, and `final_o` equals word 0 bit 15, the top bit of the most recently written command byte.
- R10: With `abort_i` high the unit is FREE (`avail_o`=1, `done_o`=0) on the following clock, from any state, and the record keeps its contents.
- R11: A run in FREE with no preceding load re-executes the command held in word 0 on the existing record.
- R12: `run_i` may be high for one or two consecutive clocks and gives exactly one execution. Three or more consecutive clocks are a protocol violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| abort_i | input | 1 | Return to FREE while held, record kept |
| load_i | input | 1 | Claim the unit and open the write path |
| wr_i | input | 1 | Write strobe |
| waddr_i | input | 4 | Word address for writes |
| wdata_i | input | 32 | Write data |
| run_i | input | 1 | Start the command in word 0 |
| avail_o | output | 1 | Unit is free |
| done_o | output | 1 | Command finished, awaiting acknowledgement |
| final_o | output | 1 | Top bit of the command byte |
| frame_id_o | output | 8 | Frame tag, word 0 bits 7:0 |
| thanks_i | input | 1 | Acknowledge a finished command |
| rd_i | input | 1 | Read strobe |
| raddr_i | input | 4 | Word address for reads |
| rdata_o | output | 32 | Registered read data |
| eng_start_o | output | 1 | One-cycle start strobe to the engine |
| eng_op_o | output | 2 | Engine operation select (1 or 2) |
| eng_arg0_o | output | 8 | First argument byte |
| eng_arg1_o | output | 8 | Second argument byte |
| eng_busy_i | input | 1 | Engine is working |

## Verification
The embedded properties assume a well-behaved scheduler and engine. `run_i` is never held for more than two clocks, `thanks_i` is raised only once `done_o` is high, and the engine raises `eng_busy_i` in the cycle after the start strobe and keeps it up for at least one clock. The stimulus drives inputs at the falling edge, so every run pulse is one or two cycles long. The engine model asserts busy right after the strobe, for a random latency of 1 to 10 cycles. Stray writes are aimed only at the busy and result states, where the block must ignore them and no property forbids them.

// File: rtl/cu_pkg.sv
package cu_pkg;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_FILL,
        ST_DECODE,
        ST_WAIT_NOP,
        ST_KICK,
        ST_WAIT_ENG,
        ST_RESULT
    } cu_state_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_SMOOTH = 2'd1,
        OP_CORR   = 2'd2
    } eng_op_t;

    localparam logic [6:0] CODE_SMOOTH = 7'd1;
    localparam logic [6:0] CODE_CORR   = 7'd2;

    // Unknown codes fall back to the internal no-operation path.
    function automatic eng_op_t decode_cmd(input logic [6:0] code);
        eng_op_t op;
        unique case (code)
            CODE_SMOOTH: op = OP_SMOOTH;
            CODE_CORR:   op = OP_CORR;
            default:     op = OP_NONE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/cu_rec_mem.sv
module cu_rec_mem #(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic [DW-1:0] word0
);

    logic [DW-1:0] words [WORDS];

    // One register per word; abort does not reach this module.
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                words[g] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= words[raddr];
        end
    end

    assign word0 = words[0];

endmodule

// File: rtl/cu_nop_timer.sv
module cu_nop_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic          zero
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else if (ld) begin
            cnt <= ld_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/cu_fsm.sv
module cu_fsm
    import cu_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      abort_i,
    input  logic      load_i,
    input  logic      wr_i,
    input  logic      run_i,
    input  logic      thanks_i,
    input  logic      busy_i,
    input  logic [6:0] code_i,
    input  logic      tmr_zero,
    output logic      avail_o,
    output logic      done_o,
    output logic      mem_we,
    output logic      tmr_ld,
    output logic      start_o,
    output eng_op_t   op_o
);

    cu_state_t state, state_nx;
    eng_op_t   op_dec;
    logic [1:0] run_len;

    assign op_dec = decode_cmd(code_i);

    // State register: abort acts as a reset for the control path.
    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            state <= ST_FREE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FREE: begin
                if (run_i) begin
                    state_nx = ST_DECODE;
                end else if (load_i) begin
                    state_nx = ST_FILL;
                end
            end
            ST_FILL: begin
                if (run_i) begin
                    state_nx = ST_DECODE;
                end
            end
            ST_DECODE: begin
                state_nx = (op_dec == OP_NONE) ? ST_WAIT_NOP : ST_KICK;
            end
            ST_WAIT_NOP: begin
                if (tmr_zero) begin
                    state_nx = ST_RESULT;
                end
            end
            ST_KICK: begin
                state_nx = ST_WAIT_ENG;
            end
            ST_WAIT_ENG: begin
                if (!busy_i) begin
                    state_nx = ST_RESULT;
                end
            end
            ST_RESULT: begin
                if (thanks_i) begin
                    state_nx = ST_FREE;
                end
            end
            default: state_nx = ST_FREE;
        endcase
    end

    // Output decode.
    always_comb begin
        avail_o = 1'b0;
        done_o  = 1'b0;
        tmr_ld  = 1'b0;
        start_o = 1'b0;
        unique case (state)
            ST_FREE:     avail_o = 1'b1;
            ST_FILL:     avail_o = 1'b0;
            ST_DECODE:   tmr_ld  = 1'b1;
            ST_WAIT_NOP: avail_o = 1'b0;
            ST_KICK:     start_o = 1'b1;
            ST_WAIT_ENG: avail_o = 1'b0;
            ST_RESULT:   done_o  = 1'b1;
            default:     avail_o = 1'b0;
        endcase
        mem_we = load_i && wr_i && !run_i && !abort_i
                 && ((state == ST_FREE) || (state == ST_FILL));
        op_o   = op_dec;
    end

    // Consecutive run cycles seen before the current one.
    always_ff @(posedge clk) begin
        if (rst) begin
            run_len <= '0;
        end else if (run_i) begin
            run_len <= (run_len == 2'd3) ? run_len : run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    AST_RUN_MAX_TWO: assert property (@(posedge clk) disable iff (rst || abort_i)
        run_i |-> (run_len < 2'd2)); // R12

    AST_LOAD_TAKES_UNIT: assert property (@(posedge clk) disable iff (rst || abort_i)
        (avail_o && (load_i || run_i)) |=> !avail_o); // R3

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst || abort_i)
        (done_o && !thanks_i) |=> (done_o && !avail_o)); // R7

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst || abort_i)
        start_o |=> !start_o); // R6

    AST_NOP_NO_START: assert property (@(posedge clk) disable iff (rst || abort_i)
        (tmr_ld && (op_o == OP_NONE)) |=> !start_o); // R5

endmodule

// File: rtl/cu_ctrl.sv
module cu_ctrl
    import cu_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS),
    localparam int BW   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort_i,
    input  logic          load_i,
    input  logic          wr_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          run_i,
    output logic          avail_o,
    output logic          done_o,
    output logic          final_o,
    output logic [BW-1:0] frame_id_o,
    input  logic          thanks_i,
    input  logic          rd_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    output logic          eng_start_o,
    output logic [1:0]    eng_op_o,
    output logic [BW-1:0] eng_arg0_o,
    output logic [BW-1:0] eng_arg1_o,
    input  logic          eng_busy_i
);

    logic [DW-1:0] word0;
    logic          mem_we;
    logic          tmr_ld;
    logic          tmr_zero;
    eng_op_t       op;

    cu_rec_mem #(.WORDS(WORDS), .DW(DW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (mem_we),
        .waddr (waddr_i),
        .wdata (wdata_i),
        .re    (rd_i),
        .raddr (raddr_i),
        .rdata (rdata_o),
        .word0 (word0)
    );

    cu_nop_timer #(.CW(BW)) u_tmr (
        .clk    (clk),
        .clr    (rst || abort_i),
        .ld     (tmr_ld),
        .ld_val (word0[2*BW +: BW]),
        .zero   (tmr_zero)
    );

    cu_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .abort_i  (abort_i),
        .load_i   (load_i),
        .wr_i     (wr_i),
        .run_i    (run_i),
        .thanks_i (thanks_i),
        .busy_i   (eng_busy_i),
        .code_i   (word0[BW +: 7]),
        .tmr_zero (tmr_zero),
        .avail_o  (avail_o),
        .done_o   (done_o),
        .mem_we   (mem_we),
        .tmr_ld   (tmr_ld),
        .start_o  (eng_start_o),
        .op_o     (op)
    );

    assign eng_op_o   = op;
    assign frame_id_o = word0[0 +: BW];
    assign final_o    = word0[2*BW-1];
    assign eng_arg0_o = word0[2*BW +: BW];
    assign eng_arg1_o = word0[3*BW +: BW];

    AST_ABORT_FREES: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> (avail_o && !done_o)); // R10

    AST_RESULT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        done_o |=> ($stable(frame_id_o) && $stable(final_o))); // R2

    AST_ABORT_KEEPS_TAG: assert property (@(posedge clk) disable iff (rst)
        (abort_i && !load_i) |=> $stable(frame_id_o)); // R10

endmodule

// File: tb/cu_ctrl_tb.sv
module cu_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        abort_i, load_i, wr_i, run_i, thanks_i, rd_i, eng_busy_i;
    logic [3:0]  waddr_i, raddr_i;
    logic [31:0] wdata_i;
    logic        avail_o, done_o, final_o, eng_start_o;
    logic [7:0]  frame_id_o, eng_arg0_o, eng_arg1_o;
    logic [31:0] rdata_o;
    logic [1:0]  eng_op_o;

    int vectors = 0;
    int misses  = 0;
    int lat     = 1;
    int starts  = 0;
    logic [1:0]  last_op = 2'd0;
    logic [31:0] model [16];

    always #5 clk = ~clk;

    cu_ctrl u_dut (
        .clk(clk), .rst(rst), .abort_i(abort_i), .load_i(load_i), .wr_i(wr_i),
        .waddr_i(waddr_i), .wdata_i(wdata_i), .run_i(run_i), .avail_o(avail_o),
        .done_o(done_o), .final_o(final_o), .frame_id_o(frame_id_o),
        .thanks_i(thanks_i), .rd_i(rd_i), .raddr_i(raddr_i), .rdata_o(rdata_o),
        .eng_start_o(eng_start_o), .eng_op_o(eng_op_o), .eng_arg0_o(eng_arg0_o),
        .eng_arg1_o(eng_arg1_o), .eng_busy_i(eng_busy_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_cycles(input logic [31:0] w0, input int l);
        if (w0[14:8] == 7'd1 || w0[14:8] == 7'd2) return l + 3;
        return int'(w0[23:16]) + 3;
    endfunction

    function automatic logic [1:0] exp_op(input logic [31:0] w0);
        if (w0[14:8] == 7'd1) return 2'd1;
        if (w0[14:8] == 7'd2) return 2'd2;
        return 2'd0;
    endfunction

    // Engine model: busy follows the start strobe for lat cycles.
    task automatic engine_model();
        forever begin
            @(negedge clk);
            if (eng_start_o) begin
                starts++;
                last_op = eng_op_o;
                eng_busy_i = 1'b1;
                repeat (lat) @(negedge clk);
                eng_busy_i = 1'b0;
            end
        end
    endtask

    task automatic read_chk(input int a, input string req);
        rd_i = 1'b1;
        raddr_i = 4'(a);
        @(negedge clk);
        rd_i = 1'b0;
        chk(req, rdata_o, model[a]);
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 16; a++) read_chk(a, req);
    endtask

    // Run the command in word 0 and check completion time and engine use.
    task automatic execute(input bit twice);
        int cnt = 0;
        int s0 = starts;
        int expc = exp_cycles(model[0], lat);
        run_i = 1'b1;
        do begin
            @(negedge clk);
            cnt++;
            chk("R3 avail low while busy", {31'd0, avail_o}, 32'd0);
            if (cnt == 1 && !twice) run_i = 1'b0;
            if (cnt == 2) begin
                run_i = 1'b0;
                load_i = 1'b1; wr_i = 1'b1;
                waddr_i = 4'($urandom_range(0, 15));
                wdata_i = $urandom;
            end
            if (cnt == 3) begin
                load_i = 1'b0; wr_i = 1'b0;
            end
        end while (!done_o && cnt < 100);
        load_i = 1'b0; wr_i = 1'b0;
        if (exp_op(model[0]) == 2'd0)
            chk("R4 nop done timing", cnt, expc);
        else
            chk("R6 engine done timing", cnt, expc);
        chk("R5 start count", starts - s0, (exp_op(model[0]) == 2'd0) ? 0 : 1);
        if (exp_op(model[0]) != 2'd0) chk("R5 engine op", {30'd0, last_op}, {30'd0, exp_op(model[0])});
        chk("R12 single execution", starts - s0, (exp_op(model[0]) == 2'd0) ? 0 : 1);
    endtask

    task automatic finish_task();
        load_i = 1'b1; wr_i = 1'b1;
        waddr_i = 4'($urandom_range(0, 15)); wdata_i = $urandom;
        @(negedge clk);
        load_i = 1'b0; wr_i = 1'b0;
        chk("R7 done held", {31'd0, done_o}, 32'd1);
        chk("R9 frame tag", {24'd0, frame_id_o}, {24'd0, model[0][7:0]});
        chk("R9 final bit", {31'd0, final_o}, {31'd0, model[0][15]});
        read_all("R2 record after result-state write");
        chk("R7 done held before thanks", {31'd0, done_o}, 32'd1);
        thanks_i = 1'b1;
        @(negedge clk);
        thanks_i = 1'b0;
        chk("R7 avail after thanks", {30'd0, avail_o, done_o}, 32'd2);
    endtask

    task automatic fill(input logic [31:0] w0, input int extra);
        load_i = 1'b1; wr_i = 1'b1; waddr_i = 4'd0; wdata_i = w0; model[0] = w0;
        @(negedge clk);
        chk("R3 avail drops on load", {31'd0, avail_o}, 32'd0);
        for (int i = 0; i < extra; i++) begin
            int a = $urandom_range(1, 15);
            waddr_i = 4'(a); wdata_i = $urandom; model[a] = wdata_i;
            @(negedge clk);
        end
        load_i = 1'b0; wr_i = 1'b0;
    endtask

    function automatic logic [31:0] rand_w0();
        logic [7:0] code;
        int pick = $urandom_range(0, 3);
        code = (pick == 3) ? 8'($urandom_range(3, 127)) : 8'(pick);
        code[7] = 1'($urandom);
        return {8'($urandom), 8'($urandom_range(0, 13)), code, 8'($urandom)};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; abort_i = 0; load_i = 0; wr_i = 0; run_i = 0; thanks_i = 0;
        rd_i = 0; eng_busy_i = 0; waddr_i = 0; raddr_i = 0; wdata_i = 0;
        for (int i = 0; i < 16; i++) model[i] = '0;
        fork engine_model(); join_none
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 avail after reset", {29'd0, avail_o, done_o, eng_start_o}, 32'd4);
        chk("R1 tag after reset", {23'd0, final_o, frame_id_o}, 32'd0);
        read_chk(7, "R1 record zero");
        read_chk(2, "R8 read word");

        // Directed: NOP with zero and maximum delay, engine ops, unknown code.
        lat = 1; fill(32'h0000_0011, 2); execute(0); finish_task();
        lat = 1; fill(32'h000D_0022, 0); execute(1); finish_task();
        lat = 4; fill(32'h5503_0133, 1); execute(0); finish_task();
        lat = 7; fill(32'h0002_0244, 3); execute(1); finish_task();
        lat = 2; fill(32'h0005_FF55, 0); execute(0); finish_task();

        // R11: re-run without a load, command byte changed only.
        lat = 3; execute(0); finish_task();
        fill({model[0][31:16], 8'h01, model[0][7:0]}, 0);
        execute(0); finish_task();
        read_all("R11 record after re-run");

        // R10: abort during a long no-operation, then during the result state.
        fill(32'h000D_0066, 2);
        run_i = 1'b1; @(negedge clk); run_i = 1'b0;
        repeat (3) @(negedge clk);
        abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
        chk("R10 free after abort", {30'd0, avail_o, done_o}, 32'd2);
        read_all("R10 record kept");
        fill(32'h0000_0077, 0); execute(0);
        abort_i = 1'b1; @(negedge clk); abort_i = 1'b0;
        chk("R10 abort in result", {30'd0, avail_o, done_o}, 32'd2);
        chk("R10 tag kept", {24'd0, frame_id_o}, 32'h77);

        // Random mix.
        for (int t = 0; t < 40; t++) begin
            lat = $urandom_range(1, 10);
            if ($urandom_range(0, 3) != 0) fill(rand_w0(), $urandom_range(0, 5));
            execute(1'($urandom));
            finish_task();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule